// File: doc/BRIEF.md
# Link Power State Controller

This block is the device-side state keeper for a host-attached modem link. It holds one of six operating states, RESET, READY, M0, M1, M2 and M3, and publishes the current state as a 3-bit code. Each power-up or hard reset leaves the block in RESET. Once the device's own initialisation reports completion, the block moves to READY. In READY the host programs the device and then writes a request to run (M0). From M0 the host can also ask for suspension (M3).

Two of the transitions come from the device itself. A programmable inactivity timer watches the physical link and doorbells. It moves the device from M0 to M1 when the link stays quiet for the programmed time, and from M1 on to the low-power M2 after a further fixed quiet period. Any link activity or doorbell in M1 or M2 brings the device back to M0. M3 ignores activity and leaves only on a host M0 request.

The block also gates two kinds of host access. Register accesses are refused in RESET, and channel start commands are accepted only in M0. Two control outputs tell the surrounding clock and power logic when operation is suspended and when low power may be entered. Host requests that are not legal in the current state are dropped and latch a sticky error flag.

Top module: `lps_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the state after that edge is RESET (code 0) and `err_flag` is 0.
- R2: From RESET the state moves to READY (code 1) on the first edge where `init_done` is high. It stays in RESET while `init_done` is low.
- R3: `reg_grant` equals `reg_access` in every state except RESET, where it is 0. This output is combinational.
- R4: A host request with `host_req_code` 0 (enter M0) moves the state to M0 (code 2) at the next edge from READY, M1, M2 or M3. In M0 the same request leaves the state in M0.
- R5: `chan_start_ok` equals `chan_start` while the state is M0 and is 0 in every other state. This output is combinational.
- R6: In M0, when `idle_limit` is L > 0 and neither `link_activity` nor `doorbell` is seen for L consecutive edges, the state becomes M1 (code 3) at the L-th such edge. Any activity restarts the count. When L is 0, the device never leaves M0 on its own.
- R7: In M1, after M2_DELAY consecutive quiet edges the state becomes M2 (code 4). M2 is entered from no state other than M1.
- R8: `link_activity` or `doorbell` in M1 or M2 returns the state to M0 at the next edge.
- R9: A host request with code 1 (enter M3) moves the state to M3 (code 5) from M0, M1 or M2. In M3, activity, doorbells and the timer have no effect, and only an enter-M0 request leaves.
- R10: These host requests are illegal: any request in RESET, an enter-M3 request in READY, and codes 2 and 3 in any state. An illegal request leaves the state unchanged and sets `err_flag`, which stays set until reset.
- R11: `op_suspended` is 1 exactly in M1, M2 and M3. `low_power_req` is 1 exactly in M2 and M3.
- R12: When a legal host request and link activity arrive together, the host request decides the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Device initialisation finished |
| host_req_valid | input | 1 | Host state request strobe |
| host_req_code | input | 2 | 0 = enter M0, 1 = enter M3, 2/3 reserved |
| link_activity | input | 1 | Physical link activity seen this cycle |
| doorbell | input | 1 | A doorbell was rung this cycle |
| idle_limit | input | CNT_W | Quiet cycles in M0 before M1; 0 disables |
| reg_access | input | 1 | Host register access attempt |
| chan_start | input | 1 | Channel start command |
| state_code | output | 3 | Current state code |
| err_flag | output | 1 | Sticky illegal-request flag |
| reg_grant | output | 1 | Register access honoured |
| chan_start_ok | output | 1 | Channel start accepted |
| op_suspended | output | 1 | Operation suspended (M1, M2, M3) |
| low_power_req | output | 1 | Low power may be entered (M2, M3) |

## Verification
State changes and the error flag are registered, so they are due one edge after the stimulus, and the bench reads them at the falling edge that follows. The grant outputs are combinational from the state, so they are read in the same cycle as the request, at a falling edge. The timer results are due exactly L quiet edges after M0 is entered, and M2_DELAY quiet edges after M1 is entered. The bench samples once one edge short of each deadline, where the old state must still hold, and once on the deadline edge, so an off-by-one count in either direction shows up.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_READY = 3'd1,
        ST_M0    = 3'd2,
        ST_M1    = 3'd3,
        ST_M2    = 3'd4,
        ST_M3    = 3'd5
    } lps_state_e;

    typedef enum logic [1:0] {
        REQ_ENTER_M0 = 2'd0,
        REQ_ENTER_M3 = 2'd1,
        REQ_RSVD_A   = 2'd2,
        REQ_RSVD_B   = 2'd3
    } lps_req_e;

    // decoded host request
    typedef struct packed {
        logic to_m0;
        logic to_m3;
        logic bad;
    } lps_req_t;

    // control view of a state
    typedef struct packed {
        logic regs_open;
        logic chan_open;
        logic suspended;
        logic low_power;
    } lps_ctl_t;

    function automatic logic m0_allowed_from(lps_state_e s);
        return s != ST_RESET;
    endfunction

    function automatic logic m3_allowed_from(lps_state_e s);
        return s inside {ST_M0, ST_M1, ST_M2, ST_M3};
    endfunction

    function automatic lps_ctl_t ctl_of(lps_state_e s);
        lps_ctl_t c;
        c.regs_open = (s != ST_RESET);
        c.chan_open = (s == ST_M0);
        c.suspended = s inside {ST_M1, ST_M2, ST_M3};
        c.low_power = s inside {ST_M2, ST_M3};
        return c;
    endfunction

endpackage

// File: rtl/lps_req_decode.sv
module lps_req_decode
    import lps_pkg::*;
(
    input  logic       req_valid,
    input  logic [1:0] req_code,
    input  lps_state_e cur_state,
    output lps_req_t   dec
);

    always_comb begin
        dec = '0;
        if (req_valid) begin
            case (lps_req_e'(req_code))
                REQ_ENTER_M0: dec.to_m0 = m0_allowed_from(cur_state);
                REQ_ENTER_M3: dec.to_m3 = m3_allowed_from(cur_state);
                default:      ;
            endcase
            dec.bad = !(dec.to_m0 || dec.to_m3);
        end
    end

endmodule

// File: rtl/lps_idle_timer.sv
module lps_idle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             armed,
    input  logic             restart,
    input  logic             activity,
    input  logic [CNT_W-1:0] target,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    assign expire = armed && !activity && (target != '0) && (cnt_q == target - ONE);

    always_ff @(posedge clk) begin
        if (rst || !armed || activity || restart || expire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + ONE;
    end

    // R6: activity always restarts the quiet count
    a_r6_activity_restarts: assert property (@(posedge clk) disable iff (rst)
        activity |=> (cnt_q == '0));

endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
    import lps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       init_done,
    input  lps_req_t   dec,
    input  logic       wake,
    input  logic       expire,
    output lps_state_e st_q,
    output logic       changing,
    output logic       err_q
);

    lps_state_e st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_RESET: if (init_done) st_d = ST_READY;
            ST_READY: if (dec.to_m0) st_d = ST_M0;
            ST_M0: begin
                if (dec.to_m3)   st_d = ST_M3;
                else if (expire) st_d = ST_M1;
            end
            ST_M1: begin
                if (dec.to_m3)               st_d = ST_M3;
                else if (dec.to_m0 || wake)  st_d = ST_M0;
                else if (expire)             st_d = ST_M2;
            end
            ST_M2: begin
                if (dec.to_m3)               st_d = ST_M3;
                else if (dec.to_m0 || wake)  st_d = ST_M0;
            end
            ST_M3: if (dec.to_m0) st_d = ST_M0;
            default: st_d = ST_RESET;
        endcase
    end

    assign changing = (st_d != st_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_RESET;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            err_q <= err_q | dec.bad;
        end
    end

    // R1: reset forces RESET
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (st_q == ST_RESET));

    // R2: no exit from RESET without init_done
    a_r2_hold_reset: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RESET && !init_done) |=> (st_q == ST_RESET));

    // R4: READY plus legal M0 request reaches M0
    a_r4_ready_to_m0: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_READY && dec.to_m0) |=> (st_q == ST_M0));

    // R7: M2 is reachable only from M1
    a_r7_m2_only_from_m1: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_M1 && st_q != ST_M2) |=> (st_q != ST_M2));

    // R9: M3 is left only on an M0 request
    a_r9_m3_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_M3 && !dec.to_m0) |=> (st_q == ST_M3));

    // R10: illegal request latches the flag, which then stays
    a_r10_bad_sets_flag: assert property (@(posedge clk) disable iff (rst)
        dec.bad |=> err_q);
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R12: a host suspend request wins over simultaneous activity
    a_r12_request_first: assert property (@(posedge clk) disable iff (rst)
        (dec.to_m3 && wake) |=> (st_q == ST_M3));

endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
    import lps_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int M2_DELAY = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_done,
    input  logic             host_req_valid,
    input  logic [1:0]       host_req_code,
    input  logic             link_activity,
    input  logic             doorbell,
    input  logic [CNT_W-1:0] idle_limit,
    input  logic             reg_access,
    input  logic             chan_start,
    output logic [2:0]       state_code,
    output logic             err_flag,
    output logic             reg_grant,
    output logic             chan_start_ok,
    output logic             op_suspended,
    output logic             low_power_req
);

    localparam logic [CNT_W-1:0] M2_TARGET = CNT_W'(M2_DELAY);

    lps_state_e state;
    lps_req_t   dec;
    lps_ctl_t   ctl;
    logic       wake;
    logic       expire;
    logic       changing;
    logic       err_q;
    logic       timer_armed;
    logic [CNT_W-1:0] timer_target;

    assign wake         = link_activity | doorbell;
    assign timer_armed  = (state == ST_M0) || (state == ST_M1);
    assign timer_target = (state == ST_M1) ? M2_TARGET : idle_limit;

    lps_req_decode u_dec (
        .req_valid (host_req_valid),
        .req_code  (host_req_code),
        .cur_state (state),
        .dec       (dec)
    );

    lps_idle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .armed    (timer_armed),
        .restart  (changing),
        .activity (wake),
        .target   (timer_target),
        .expire   (expire)
    );

    lps_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .init_done (init_done),
        .dec       (dec),
        .wake      (wake),
        .expire    (expire),
        .st_q      (state),
        .changing  (changing),
        .err_q     (err_q)
    );

    assign ctl           = ctl_of(state);
    assign state_code    = state;
    assign err_flag      = err_q;
    assign reg_grant     = reg_access & ctl.regs_open;
    assign chan_start_ok = chan_start & ctl.chan_open;
    assign op_suspended  = ctl.suspended;
    assign low_power_req = ctl.low_power;

    // R8: activity in M1 or M2 without a host request returns to M0
    a_r8_wake_to_m0: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_M1 || state == ST_M2) && wake && !host_req_valid)
        |=> (state_code == 3'd2));

endmodule

// File: tb/lps_ctrl_bench.sv
`timescale 1ns/1ps
module lps_ctrl_bench;

    localparam int CNT_W = 16;
    localparam int M2D   = 6;

    logic clk = 1'b0;
    logic rst, init_done, host_req_valid, link_activity, doorbell, reg_access, chan_start;
    logic [1:0] host_req_code;
    logic [CNT_W-1:0] idle_limit;
    logic [2:0] state_code;
    logic err_flag, reg_grant, chan_start_ok, op_suspended, low_power_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    lps_ctrl #(.CNT_W(CNT_W), .M2_DELAY(M2D)) u_lps_ctrl (
        .clk(clk), .rst(rst), .init_done(init_done),
        .host_req_valid(host_req_valid), .host_req_code(host_req_code),
        .link_activity(link_activity), .doorbell(doorbell),
        .idle_limit(idle_limit), .reg_access(reg_access), .chan_start(chan_start),
        .state_code(state_code), .err_flag(err_flag), .reg_grant(reg_grant),
        .chan_start_ok(chan_start_ok), .op_suspended(op_suspended),
        .low_power_req(low_power_req)
    );

    // {init, req_valid, req_code, act, db, exp_state, exp_err}
    typedef struct packed {
        logic       init;
        logic       rv;
        logic [1:0] code;
        logic       act;
        logic       db;
        logic [2:0] st;
        logic       err;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0},  // idle in RESET
        '{1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 3'd1, 1'b0},  // init -> READY
        '{1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 3'd1, 1'b0},
        '{1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 3'd1, 1'b0},  // activity ignored in READY
        '{1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 3'd2, 1'b0},  // M0 request
        '{1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 3'd2, 1'b0},
        '{1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 3'd2, 1'b0},  // M0 in M0: no-op
        '{1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 3'd5, 1'b0},  // M3 request
        '{1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 3'd5, 1'b0},  // activity ignored in M3
        '{1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 3'd5, 1'b0},  // doorbell ignored in M3
        '{1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 3'd5, 1'b0},
        '{1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 3'd2, 1'b0},  // M0 leaves M3
        '{1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 3'd5, 1'b0},  // request beats activity
        '{1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 3'd2, 1'b0},
        '{1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 3'd2, 1'b1},  // reserved code
        '{1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 3'd2, 1'b1}   // flag sticky
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic clear_in();
        init_done = 0; host_req_valid = 0; host_req_code = 2'd0;
        link_activity = 0; doorbell = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        clear_in();
        tick(2);
        rst = 1'b0;
    endtask

    task automatic req(input logic [1:0] code);
        host_req_valid = 1'b1; host_req_code = code;
        tick(1);
        host_req_valid = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; idle_limit = '0; reg_access = 1'b0; chan_start = 1'b0;
        clear_in();
        tick(2);
        rst = 1'b0;

        // table walk: one edge per row
        for (int i = 0; i < NV; i++) begin
            init_done      = VEC[i].init;
            host_req_valid = VEC[i].rv;
            host_req_code  = VEC[i].code;
            link_activity  = VEC[i].act;
            doorbell       = VEC[i].db;
            tick(1);
            chk($sformatf("R4 R9 R10 R12 row %0d state", i), int'(state_code), int'(VEC[i].st));
            chk($sformatf("R10 row %0d err", i), int'(err_flag), int'(VEC[i].err));
        end
        clear_in();

        // reset state and gates
        reg_access = 1'b1; chan_start = 1'b1;
        do_reset();
        chk("R1 reset state", int'(state_code), 0);
        chk("R1 reset clears err", int'(err_flag), 0);
        chk("R3 no grant in RESET", int'(reg_grant), 0);
        chk("R5 no chan start in RESET", int'(chan_start_ok), 0);
        chk("R11 not suspended in RESET", int'(op_suspended), 0);
        tick(3);
        chk("R2 held in RESET", int'(state_code), 0);

        req(2'd0);
        chk("R10 request in RESET ignored", int'(state_code), 0);
        chk("R10 request in RESET flags", int'(err_flag), 1);
        chk("R3 still no grant", int'(reg_grant), 0);

        do_reset();
        chk("R1 err cleared", int'(err_flag), 0);
        init_done = 1'b1; tick(1); init_done = 1'b0;
        chk("R2 READY", int'(state_code), 1);
        chk("R3 grant in READY", int'(reg_grant), 1);
        chk("R5 no chan start in READY", int'(chan_start_ok), 0);
        req(2'd1);
        chk("R10 M3 in READY ignored", int'(state_code), 1);
        chk("R10 M3 in READY flags", int'(err_flag), 1);

        // timers
        do_reset();
        idle_limit = CNT_W'(5);
        init_done = 1'b1; tick(1); init_done = 1'b0;
        req(2'd0);
        chk("R4 M0", int'(state_code), 2);
        chk("R5 chan start in M0", int'(chan_start_ok), 1);
        tick(4);
        chk("R6 still M0 before limit", int'(state_code), 2);
        tick(1);
        chk("R6 M1 at limit", int'(state_code), 3);
        chk("R11 M1 suspended", int'(op_suspended), 1);
        chk("R11 M1 not low power", int'(low_power_req), 0);
        chk("R5 no chan start in M1", int'(chan_start_ok), 0);

        link_activity = 1'b1; tick(1); link_activity = 1'b0;
        chk("R8 activity M1 to M0", int'(state_code), 2);
        tick(3);
        link_activity = 1'b1; tick(1); link_activity = 1'b0;
        tick(4);
        chk("R6 activity restarted count", int'(state_code), 2);
        tick(1);
        chk("R6 M1 after restart", int'(state_code), 3);
        tick(M2D - 1);
        chk("R7 still M1 before delay", int'(state_code), 3);
        tick(1);
        chk("R7 M2 after delay", int'(state_code), 4);
        chk("R11 M2 low power", int'(low_power_req), 1);
        chk("R11 M2 suspended", int'(op_suspended), 1);

        doorbell = 1'b1; tick(1); doorbell = 1'b0;
        chk("R8 doorbell M2 to M0", int'(state_code), 2);

        tick(5 + M2D);
        chk("R7 back in M2", int'(state_code), 4);
        req(2'd1);
        chk("R9 M2 to M3", int'(state_code), 5);
        chk("R11 M3 low power", int'(low_power_req), 1);
        link_activity = 1'b1; tick(3); link_activity = 1'b0;
        tick(20);
        chk("R9 M3 holds", int'(state_code), 5);
        chk("R5 no chan start in M3", int'(chan_start_ok), 0);
        req(2'd0);
        chk("R9 M0 leaves M3", int'(state_code), 2);

        tick(5);
        chk("R6 M1 again", int'(state_code), 3);
        link_activity = 1'b1;
        req(2'd1);
        link_activity = 1'b0;
        chk("R12 request beats activity in M1", int'(state_code), 5);
        chk("R10 legal requests leave err clear", int'(err_flag), 0);

        req(2'd0);
        idle_limit = '0;
        tick(30);
        chk("R6 zero limit disables timeout", int'(state_code), 2);

        done = 1'b1;
        report();
        $finish;
    end

endmodule